// File: doc/BRIEF.md
# Indirect Dword Window onto a Register Array

This block lets configuration software reach a large memory-mapped register array through a small, fixed 8-byte window in configuration space. Software writes a dword index into a select byte and then reads or writes a 32-bit data register. The data register is a local copy of the array dword that the select value points at. A write to the data register is pushed to the array as a whole dword. Any write that lands in the window starts a refresh of the copy from the array.

The window sits at a parameterised, dword-aligned configuration offset. Window byte 2 holds the select value, and window byte 3 is a read-only status byte that carries two pending flags from outside. Window bytes 4 to 7 hold the data copy. Window bytes 0 and 1 belong to the capability header, which is kept elsewhere; this block reads them as zero. The register array and its write semantics live outside the block. The array takes a dword write or read strobe with a byte address, and it returns read data one clock after the read strobe.

The sequencer has four states:
- `ST_IDLE`: ready; accepts window writes.
- `ST_PUSH`: forwards the data dword to the array.
- `ST_FETCH`: issues the array read.
- `ST_LOAD`: captures the returned dword into the data copy.

The transitions are:
- IDLE→PUSH on a write that touches the data bytes.
- IDLE→FETCH on any other write that touches the window.
- PUSH→FETCH, FETCH→LOAD and LOAD→IDLE, each unconditional.

Top module: `cfg_dword_window`

## Requirements
- R1: After reset the select value and the data copy are zero, `ready` is 1, and neither `arr_wr_en` nor `arr_rd_en` is asserted.
- R2: A read at the window's first dword returns {status byte, select byte, 16'h0000}, with the status byte in bits 31:24 and the select byte in bits 23:16. A read at the second dword returns the data copy. Any other address reads zero.
- R3: Status bit 2 (rdata bit 26) reflects `pend_flags[0]` and status bit 3 (rdata bit 27) reflects `pend_flags[1]`. All other status bits read zero, and writes to the status byte (byte enable 3 of the first dword) do not change it.
- R4: A configuration write whose address is outside the window changes no window state. It leaves `ready` high and produces no array strobe.
- R5: A write to the first dword with `cfg_be[2]` set loads select from `cfg_wdata[23:16]`. It then refreshes the data copy without any array write.
- R6: A write to the second dword merges the enabled bytes into the data copy. In the next cycle the block asserts `arr_wr_en` with the whole merged dword at byte address select×4.
- R7: After every accepted window write, the block issues `arr_rd_en` at select×4 and loads the data copy from `arr_rdata` one cycle later. `ready` is low from the edge that accepts the write until the cycle in which the new copy is visible: 3 cycles after a data write, 2 cycles after any other window write.
- R8: When select×4 is at or beyond `ARR_BYTES`, no array strobe is issued, the forwarded write is dropped, and the data copy reloads as zero.
- R9: Configuration writes that arrive while `ready` is low are dropped.
- R10: A window write with all byte enables clear touches nothing: it starts no refresh and issues no array strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration byte address (dword aligned; bits 1:0 ignored) |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| pend_flags | input | 2 | Pending flags shown in status bits 2 and 3 |
| ready | output | 1 | High when idle and the data copy is current |
| arr_wr_en | output | 1 | Array dword write strobe |
| arr_rd_en | output | 1 | Array dword read strobe |
| arr_addr | output | SEL_W+2 | Array byte address (select×4) |
| arr_wdata | output | 32 | Array write data |
| arr_rdata | input | 32 | Array read data, valid one cycle after `arr_rd_en` |

## Verification
A sequencer stuck in or skipping a state shows up at once as a wrong `ready` level or a missing or extra array strobe in the cycle that follows. A wrong select or data register shows up on the very next read of the window, or as a wrong `arr_addr` or `arr_wdata` in the push cycle. A bad range decision shows up as a strobe beyond the array, or as a non-zero copy three cycles after the write that chose an out-of-range dword. The bench models the window and the array behaviourally and compares every output on every clock, so each such fault is reported in the cycle it first appears.

// File: rtl/cdw_pkg.sv
package cdw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PUSH  = 2'd1,
        ST_FETCH = 2'd2,
        ST_LOAD  = 2'd3
    } cdw_state_e;

    // byte lanes inside the first window dword
    localparam int SEL_LANE  = 2;
    localparam int STAT_LANE = 3;
    // position of the pending flags within the status byte
    localparam int FLAG_LSB  = 2;
    localparam int LANES     = 4;
endpackage

// File: rtl/cdw_fsm.sv
module cdw_fsm
    import cdw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,        // accepted window write
    input  logic start_push,   // that write touched the data dword
    output logic ready,
    output logic push_ph,
    output logic fetch_ph,
    output logic load_ph
);
    cdw_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = start_push ? ST_PUSH : ST_FETCH;
            ST_PUSH:  state_d = ST_FETCH;
            ST_FETCH: state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        ready    = 1'b0;
        push_ph  = 1'b0;
        fetch_ph = 1'b0;
        load_ph  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ready    = 1'b1;
            ST_PUSH:  push_ph  = 1'b1;
            ST_FETCH: fetch_ph = 1'b1;
            ST_LOAD:  load_ph  = 1'b1;
            default:  ready    = 1'b0;
        endcase
    end
endmodule

// File: rtl/cdw_regs.sv
module cdw_regs
    import cdw_pkg::*;
#(
    parameter int SEL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wval,
    input  logic [LANES-1:0] data_be,
    input  logic [31:0]      data_wval,
    input  logic             load_en,
    input  logic [31:0]      load_val,
    output logic [SEL_W-1:0] sel_q,
    output logic [31:0]      data_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (sel_we) sel_q <= sel_wval;
    end

    // one byte lane of the data copy per generate branch (R6 merge)
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                data_q[8*g +: 8] <= 8'h00;
            else if (load_en)
                data_q[8*g +: 8] <= load_val[8*g +: 8];
            else if (data_be[g])
                data_q[8*g +: 8] <= data_wval[8*g +: 8];
        end
    end
endmodule

// File: rtl/cdw_arr_port.sv
module cdw_arr_port #(
    parameter int SEL_W     = 8,
    parameter int ARR_BYTES = 160
) (
    input  logic             push_ph,
    input  logic             fetch_ph,
    input  logic [SEL_W-1:0] sel_q,
    input  logic [31:0]      data_q,
    input  logic [31:0]      arr_rdata,
    output logic             arr_wr_en,
    output logic             arr_rd_en,
    output logic [SEL_W+1:0] arr_addr,
    output logic [31:0]      arr_wdata,
    output logic [31:0]      load_val
);
    localparam int ARR_DWORDS = ARR_BYTES / 4;

    logic in_range;

    always_comb begin
        in_range  = 32'(sel_q) < 32'(ARR_DWORDS);   // R8
        arr_addr  = {sel_q, 2'b00};
        arr_wdata = data_q;
        arr_wr_en = push_ph  && in_range;
        arr_rd_en = fetch_ph && in_range;
        load_val  = in_range ? arr_rdata : 32'h0;
    end
endmodule

// File: rtl/cfg_dword_window.sv
module cfg_dword_window
    import cdw_pkg::*;
#(
    parameter int CFG_AW    = 8,
    parameter int CAP_BASE  = 'h50,
    parameter int SEL_W     = 8,
    parameter int ARR_BYTES = 160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [1:0]        pend_flags,
    output logic              ready,
    output logic              arr_wr_en,
    output logic              arr_rd_en,
    output logic [SEL_W+1:0]  arr_addr,
    output logic [31:0]       arr_wdata,
    input  logic [31:0]       arr_rdata
);
    localparam logic [CFG_AW-3:0] HDR_DW  = (CFG_AW-2)'(CAP_BASE / 4);
    localparam logic [CFG_AW-3:0] DATA_DW = (CFG_AW-2)'(CAP_BASE / 4 + 1);

    logic             hit_hdr, hit_data, accept;
    logic             push_ph, fetch_ph, load_ph;
    logic [SEL_W-1:0] sel_q;
    logic [31:0]      data_q, load_val;

    always_comb begin
        hit_hdr  = cfg_addr[CFG_AW-1:2] == HDR_DW;
        hit_data = cfg_addr[CFG_AW-1:2] == DATA_DW;
        // R4, R9, R10: only an idle, in-window write with some byte enabled
        accept   = cfg_wr_en && ready && (hit_hdr || hit_data) && (cfg_be != 4'b0000);
    end

    cdw_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .start_push (hit_data),
        .ready      (ready),
        .push_ph    (push_ph),
        .fetch_ph   (fetch_ph),
        .load_ph    (load_ph)
    );

    cdw_regs #(.SEL_W(SEL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_we    (accept && hit_hdr && cfg_be[SEL_LANE]),
        .sel_wval  (cfg_wdata[8*SEL_LANE +: SEL_W]),
        .data_be   ((accept && hit_data) ? cfg_be : 4'b0000),
        .data_wval (cfg_wdata),
        .load_en   (load_ph),
        .load_val  (load_val),
        .sel_q     (sel_q),
        .data_q    (data_q)
    );

    cdw_arr_port #(.SEL_W(SEL_W), .ARR_BYTES(ARR_BYTES)) u_port (
        .push_ph   (push_ph),
        .fetch_ph  (fetch_ph),
        .sel_q     (sel_q),
        .data_q    (data_q),
        .arr_rdata (arr_rdata),
        .arr_wr_en (arr_wr_en),
        .arr_rd_en (arr_rd_en),
        .arr_addr  (arr_addr),
        .arr_wdata (arr_wdata),
        .load_val  (load_val)
    );

    // R2/R3 read view: header bytes 0..1 read as zero here
    always_comb begin
        cfg_rdata = 32'h0;
        if (hit_hdr) begin
            cfg_rdata[8*STAT_LANE + FLAG_LSB +: 2] = pend_flags;
            cfg_rdata[8*SEL_LANE +: 8]             = 8'(sel_q);
        end else if (hit_data) begin
            cfg_rdata = data_q;
        end
    end
endmodule

// File: rtl/cdw_chk.sv
module cdw_chk #(
    parameter int CFG_AW    = 8,
    parameter int CAP_BASE  = 'h50,
    parameter int SEL_W     = 8,
    parameter int ARR_BYTES = 160
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic              ready,
    input logic              arr_wr_en,
    input logic              arr_rd_en,
    input logic [SEL_W+1:0]  arr_addr
);
    logic in_win;
    assign in_win = (32'(cfg_addr) >= 32'(CAP_BASE)) && (32'(cfg_addr) < 32'(CAP_BASE + 8));

    // R7: the array never sees a write and a read together
    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_wr_en && arr_rd_en));

    // R7: strobes only while the window is busy
    p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_en || arr_rd_en) |-> !ready);

    // R6: a forwarded write is followed by the read-back at the same address
    p_push_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |=> (arr_rd_en && arr_addr == $past(arr_addr)));

    // R8: no strobe reaches past the implemented array
    p_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_en || arr_rd_en) |-> (32'(arr_addr) < 32'(ARR_BYTES)));

    // R4: writes outside the window leave the block idle
    p_outside_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cfg_wr_en && !in_win) |=> ready);

    // R7: the copy becomes current two cycles after the read strobe
    p_fetch_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_rd_en |=> (!ready ##1 ready));
endmodule

bind cfg_dword_window cdw_chk #(
    .CFG_AW(CFG_AW), .CAP_BASE(CAP_BASE), .SEL_W(SEL_W), .ARR_BYTES(ARR_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_addr  (cfg_addr),
    .ready     (ready),
    .arr_wr_en (arr_wr_en),
    .arr_rd_en (arr_rd_en),
    .arr_addr  (arr_addr)
);

// File: tb/cfg_dword_window_tb_top.sv
module cfg_dword_window_tb_top;
    localparam int CFG_AW    = 8;
    localparam int CAP_BASE  = 'h50;
    localparam int SEL_W     = 8;
    localparam int ARR_BYTES = 160;
    localparam int NDW       = ARR_BYTES / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;
    logic [1:0]  pend_flags = 2'b00;
    logic        ready, arr_wr_en, arr_rd_en;
    logic [9:0]  arr_addr;
    logic [31:0] arr_wdata;
    logic [31:0] arr_rdata = 32'h0;

    always #4 clk = ~clk;   // 125 MHz

    cfg_dword_window #(.CFG_AW(CFG_AW), .CAP_BASE(CAP_BASE), .SEL_W(SEL_W),
                       .ARR_BYTES(ARR_BYTES)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pend_flags(pend_flags), .ready(ready), .arr_wr_en(arr_wr_en),
        .arr_rd_en(arr_rd_en), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_rdata(arr_rdata));

    // array stand-in: full 256-dword index space so stray accesses are visible
    logic [31:0] mem [0:255];
    always @(posedge clk) begin
        if (arr_wr_en) mem[arr_addr[9:2]] <= arr_wdata;
        if (arr_rd_en) arr_rdata <= mem[arr_addr[9:2]];
    end

    // behavioural reference
    int          m_phase;      // 0 idle, 1 push, 2 fetch, 3 load
    int          m_sel;
    logic [31:0] m_data;
    logic [31:0] m_mem [0:255];
    bit          m_valid = 0;
    int          n_tests = 0, n_fail = 0;
    bit          fin = 0;
    string       cur_req = "R1";

    function automatic bit in_rng(int s);
        return s < NDW;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_sel = 0; m_data = 32'h0; m_valid = 1;
        end else begin
            case (m_phase)
                0: if (cfg_wr_en && (cfg_addr[7:2] == CAP_BASE/4 || cfg_addr[7:2] == CAP_BASE/4 + 1)
                       && cfg_be != 4'h0) begin
                       if (cfg_addr[7:2] == CAP_BASE/4) begin
                           if (cfg_be[2]) m_sel = int'(cfg_wdata[23:16]);
                           m_phase = 2;
                       end else begin
                           for (int b = 0; b < 4; b++)
                               if (cfg_be[b]) m_data[8*b +: 8] = cfg_wdata[8*b +: 8];
                           m_phase = 1;
                       end
                   end
                1: begin if (in_rng(m_sel)) m_mem[m_sel] = m_data; m_phase = 2; end
                2: m_phase = 3;
                default: begin m_data = in_rng(m_sel) ? m_mem[m_sel] : 32'h0; m_phase = 0; end
            endcase
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_valid && !fin) begin
            logic [31:0] exp_rd;
            bit          en_w, en_r;
            exp_rd = 32'h0;
            if (cfg_addr[7:2] == CAP_BASE/4)
                exp_rd = {4'b0, pend_flags, 2'b0, 8'(m_sel), 16'h0};
            else if (cfg_addr[7:2] == CAP_BASE/4 + 1)
                exp_rd = m_data;
            en_w = (m_phase == 1) && in_rng(m_sel);
            en_r = (m_phase == 2) && in_rng(m_sel);
            check(cur_req, "ready",     32'(ready),     32'(m_phase == 0));
            check(cur_req, "arr_wr_en", 32'(arr_wr_en), 32'(en_w));
            check(cur_req, "arr_rd_en", 32'(arr_rd_en), 32'(en_r));
            check(cur_req, "cfg_rdata", cfg_rdata,      exp_rd);
            if (en_w || en_r) check(cur_req, "arr_addr", 32'(arr_addr), 32'(m_sel * 4));
            if (en_w)         check(cur_req, "arr_wdata", arr_wdata, m_data);
        end
    end

    task automatic cfg_wr(logic [7:0] a, logic [3:0] be, logic [31:0] d);
        @(posedge clk); #1;
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr_en = 1'b0;
    endtask

    task automatic settle();
        while (ready !== 1'b1) @(posedge clk);
        @(posedge clk); #1;
    endtask

    task automatic look(logic [7:0] a);
        @(posedge clk); #1; cfg_addr = a;
        @(posedge clk); #1;
    endtask

    localparam logic [7:0] A_HDR  = 8'(CAP_BASE);
    localparam logic [7:0] A_DATA = 8'(CAP_BASE + 4);

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]   = 32'h5A00_0000 ^ (i * 32'h0101_0307);
            m_mem[i] = 32'h5A00_0000 ^ (i * 32'h0101_0307);
        end
        cur_req = "R1";
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        look(A_HDR); look(A_DATA);

        cur_req = "R2";
        look(8'h00); look(8'h4C); look(8'h58); look(A_HDR + 8'd2);

        cur_req = "R3";
        pend_flags = 2'b01; look(A_HDR);
        pend_flags = 2'b10; look(A_HDR);
        pend_flags = 2'b11; look(A_HDR);
        cfg_wr(A_HDR, 4'b1000, 32'hFF00_0000); settle();
        look(A_HDR);

        cur_req = "R4";
        cfg_wr(8'h4C, 4'hF, 32'h0A0B_0C0D);
        cfg_wr(8'h58, 4'hF, 32'h1234_5678);
        cfg_wr(8'h00, 4'b0100, 32'h00FF_0000);
        look(A_HDR); look(A_DATA);

        cur_req = "R10";
        cfg_wr(A_DATA, 4'h0, 32'hFFFF_FFFF);
        cfg_wr(A_HDR,  4'h0, 32'h0011_0000);
        look(A_DATA);

        cur_req = "R5";
        cfg_wr(A_HDR, 4'b0100, 32'h0005_0000); settle(); look(A_DATA);
        cfg_wr(A_HDR, 4'b1111, 32'hFF11_ABCD); settle(); look(A_HDR); look(A_DATA);

        cur_req = "R6";
        cfg_wr(A_DATA, 4'hF, 32'hDEAD_BEEF); settle(); look(A_DATA);
        cfg_wr(A_DATA, 4'b0010, 32'h0000_5500); settle(); look(A_DATA);
        cfg_wr(A_HDR, 4'b0100, 32'h0003_0000); settle();
        cfg_wr(A_DATA, 4'b1001, 32'hC100_00C2); settle();

        cur_req = "R7";
        cfg_wr(A_HDR, 4'b0100, 32'h0011_0000); settle(); look(A_DATA);
        cfg_wr(A_HDR, 4'b0011, 32'h0000_FFFF); settle(); look(A_DATA);

        cur_req = "R9";
        cfg_wr(A_DATA, 4'hF, 32'h1111_2222);
        cfg_wr(A_HDR, 4'b0100, 32'h0007_0000);
        cfg_wr(A_DATA, 4'hF, 32'h3333_4444);
        settle(); look(A_HDR); look(A_DATA);

        cur_req = "R8";
        cfg_wr(A_HDR, 4'b0100, 32'h0027_0000); settle(); look(A_DATA);
        cfg_wr(A_HDR, 4'b0100, 32'h0028_0000); settle(); look(A_DATA);
        cfg_wr(A_DATA, 4'hF, 32'hBAD0_BAD0); settle(); look(A_DATA);
        cfg_wr(A_HDR, 4'b0100, 32'h00FF_0000); settle(); look(A_DATA);
        cfg_wr(A_HDR, 4'b0100, 32'h0005_0000); settle(); look(A_DATA);
        for (int i = 0; i < 256; i++)
            check("R8", "array contents", mem[i], m_mem[i]);

        repeat (2) @(posedge clk);
        fin = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            fin = 1;
            n_tests++; n_fail++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule